// File: doc/BRIEF.md
# I2C Start/Stop Condition Detector

This block watches the clock and data lines of an I2C bus and reports bus start and stop conditions through a small register interface. Each line first crosses into the module clock domain through a two-flop synchroniser. It then passes through a programmable glitch filter that rejects any pulse lasting up to a chosen number of module clock cycles. Start and stop are judged on the filtered lines. A start is data falling while the clock is high. A stop is data rising while the clock is high.

A detected condition sets a sticky flag. Software clears each flag by writing 1 to its bit. An enable bit lets either flag raise a shared interrupt-pending flag, which drives the interrupt output. The pending flag is re-armed from the detect flags on every cycle. Software must therefore clear the detect flag before it clears the pending flag.

The block also tracks whether the bus is busy, which is the time between a start and the following stop. When the holdoff enable bit is set, a request to enter low-power stop mode is held off while the bus is busy.

Register map. Address 0 holds the configuration register: bits [3:0] are the filter factor, bit 4 is the detect interrupt enable and bit 5 is the holdoff enable; bits [7:6] read as 0. Address 1 holds the status register: bit 0 is the start flag, bit 1 is the stop flag and bit 2 is the pending flag; all three are write-1-to-clear and the other bits read as 0. A read returns, one cycle later and registered, the value the addressed register held before that clock edge.

Top module: `i2c_cond_detect`

## Requirements
- R1: While reset is high and after it falls, every flag, both enable bits and the filter factor are 0; rd_data, irq and stop_hold are 0; both filtered lines idle high.
- R2: With filter factor 0 the filter is bypassed, so a data-low pulse of a single module clock cycle while the clock line is high is seen as a start followed by a stop.
- R3: With filter factor n (1 to 15), a pulse on either line that lasts n module clock cycles or fewer does not reach the filtered line and sets no flag.
- R4: With filter factor n, a level held for n+1 consecutive module clock cycles does pass the filter.
- R5: Data falling while the filtered clock line is high sets the start flag (status bit 0). A start and a stop are never detected in the same cycle.
- R6: Data rising while the filtered clock line is high sets the stop flag (status bit 1). Data changes while the clock line is low set neither flag.
- R7: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 leaves it unchanged, and a flag is cleared only by such a write.
- R8: When the enable bit (configuration bit 4) is 1, a set start or stop flag sets the pending flag (status bit 2) on the next cycle. When the enable bit is 0, the pending flag does not become set. irq follows the pending flag.
- R9: Writing 1 to the pending bit while a start or stop flag is still set leaves the pending flag set. Clearing the detect flag first and then the pending flag leaves both clear.
- R10: stop_hold is 1 only while stop_req is 1, the holdoff enable (configuration bit 5) is 1 and the bus is between a start and a stop. With holdoff disabled, stop_hold stays 0.
- R11: A write to address 0 sets the filter factor and both enable bits, and a read of address 0 returns them in the configuration layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 configuration, 1 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Registered read data |
| scl_in | input | 1 | Raw I2C clock line |
| sda_in | input | 1 | Raw I2C data line |
| stop_req | input | 1 | Request to enter low-power stop mode |
| irq | output | 1 | Interrupt, equal to the pending flag |
| stop_hold | output | 1 | Stop-mode entry held off |

## Verification
The assertions assume that the raw bus lines are asynchronous to the module clock. They also assume that software clears flags only through the status address. They rely on the synchronisers and the filter never letting both filtered lines change in a way that yields a start and a stop at once. The stimulus changes pins and register inputs only on the falling clock edge and holds each bus level for whole cycles. It exercises the filter with pulses one cycle shorter and one cycle longer than the configured width. It issues status writes in both the correct and the reversed clearing order.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int unsigned AW      = 1;
  localparam int unsigned DW      = 8;
  localparam int unsigned FW      = 4;
  localparam logic [AW-1:0] CFG_ADDR  = 1'b0;
  localparam logic [AW-1:0] STAT_ADDR = 1'b1;
  localparam int unsigned B_START = 0;
  localparam int unsigned B_STOP  = 1;
  localparam int unsigned B_PEND  = 2;
  localparam int unsigned B_IE    = FW;
  localparam int unsigned B_HOLD  = FW + 1;
  localparam int unsigned L_SCL   = 1;
  localparam int unsigned L_SDA   = 0;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int unsigned FW = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] factor,
  input  logic          din,
  output logic          dout
);
  logic [FW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= RST_VAL;
      run_cnt <= '0;
    end else if (din == dout) begin
      run_cnt <= '0;
    end else if (run_cnt == factor) begin
      dout    <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_cond.sv
module bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic busy
);
  logic scl_q, sda_q;

  assign start_p = scl_f & scl_q &  sda_q & ~sda_f;
  assign stop_p  = scl_f & scl_q & ~sda_q &  sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_p)     busy <= 1'b1;
      else if (stop_p) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          stop_req,
  output logic          irq,
  output logic          stop_hold
);
  localparam int unsigned NL = 2;

  logic [NL-1:0] raw, synced, filt;
  logic [FW-1:0] factor;
  logic          det_ie, hold_en;
  logic          start_flag, stop_flag, pending;
  logic          start_p, stop_p, busy;
  logic          w_cfg, w_stat;

  assign raw[L_SCL] = scl_in;
  assign raw[L_SDA] = sda_in;

  line_sync #(.W(NL), .RST_VAL({NL{1'b1}})) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(synced)
  );

  for (genvar i = 0; i < NL; i++) begin : g_filt
    glitch_filter #(.FW(FW), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst(rst), .factor(factor), .din(synced[i]), .dout(filt[i])
    );
  end

  bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_f(filt[L_SCL]), .sda_f(filt[L_SDA]),
    .start_p(start_p), .stop_p(stop_p), .busy(busy)
  );

  assign w_cfg  = wr_en && (wr_addr == CFG_ADDR);
  assign w_stat = wr_en && (wr_addr == STAT_ADDR);
  assign irq    = pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      factor     <= '0;
      det_ie     <= 1'b0;
      hold_en    <= 1'b0;
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      pending    <= 1'b0;
      stop_hold  <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (w_cfg) begin
        factor  <= wr_data[FW-1:0];
        det_ie  <= wr_data[B_IE];
        hold_en <= wr_data[B_HOLD];
      end
      start_flag <= start_p | (start_flag & ~(w_stat & wr_data[B_START]));
      stop_flag  <= stop_p  | (stop_flag  & ~(w_stat & wr_data[B_STOP]));
      pending    <= (det_ie & (start_flag | stop_flag))
                  | (pending & ~(w_stat & wr_data[B_PEND]));
      stop_hold  <= stop_req & hold_en & busy;
      rd_data    <= '0;
      if (rd_addr == CFG_ADDR) begin
        rd_data[FW-1:0] <= factor;
        rd_data[B_IE]   <= det_ie;
        rd_data[B_HOLD] <= hold_en;
      end else begin
        rd_data[B_START] <= start_flag;
        rd_data[B_STOP]  <= stop_flag;
        rd_data[B_PEND]  <= pending;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk
  import i2c_cond_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          start_p,
  input logic          stop_p,
  input logic          start_flag,
  input logic          stop_flag,
  input logic          pending,
  input logic          det_ie,
  input logic          hold_en,
  input logic          busy,
  input logic          stop_hold
);
  // R5
  start_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(start_flag) |-> $past(start_p));
  // R5
  one_cond_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_p && stop_p));
  // R6
  stop_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_flag) |-> $past(stop_p));
  // R7
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(start_flag) |-> $past(wr_en && wr_addr == STAT_ADDR && wr_data[B_START]));
  // R7
  stop_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_flag) |-> $past(wr_en && wr_addr == STAT_ADDR && wr_data[B_STOP]));
  // R8
  pend_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!det_ie && !pending) |=> !pending);
  // R9
  pend_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (det_ie && (start_flag || stop_flag)) |=> pending);
  // R10
  hold_en_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!hold_en) |-> !stop_hold);
  // R10
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    stop_hold |-> $past(busy));
endmodule

bind i2c_cond_detect i2c_cond_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .start_p(start_p), .stop_p(stop_p), .start_flag(start_flag),
  .stop_flag(stop_flag), .pending(pending), .det_ie(det_ie),
  .hold_en(hold_en), .busy(busy), .stop_hold(stop_hold)
);

// File: tb/sim_i2c_cond_detect.sv
`timescale 1ns/1ps
module sim_i2c_cond_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b1;
  logic [7:0] rd_data;
  logic       scl = 1'b1, sda = 1'b1, stop_req = 1'b0;
  logic       irq, stop_hold;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_cond_detect u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .scl_in(scl), .sda_in(sda),
    .stop_req(stop_req), .irq(irq), .stop_hold(stop_hold)
  );

  // behavioural reference model
  logic [1:0] pin_q[$];
  int  run[2];
  bit  lvl[2], lvl_old[2];
  int  m_fac;
  bit  m_ie, m_hold_en, m_sf, m_pf, m_pend, m_busy, m_hold;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      pin_q = '{2'b11, 2'b11};
      run = '{0, 0}; lvl = '{1, 1}; lvl_old = '{1, 1};
      m_fac = 0; m_ie = 0; m_hold_en = 0; m_sf = 0; m_pf = 0;
      m_pend = 0; m_busy = 0; m_hold = 0; m_rd = 0;
    end else begin
      bit st, sp, clr_s, clr_p, clr_i, n_hold, n_pend;
      logic [1:0] oldest;
      int fac_now;
      // decode conditions on the model's current filtered levels
      st = lvl[1] && lvl_old[1] && lvl_old[0] && !lvl[0];
      sp = lvl[1] && lvl_old[1] && !lvl_old[0] && lvl[0];
      clr_s = wr_en && wr_addr && wr_data[0];
      clr_p = wr_en && wr_addr && wr_data[1];
      clr_i = wr_en && wr_addr && wr_data[2];
      n_hold = stop_req && m_hold_en && m_busy;
      n_pend = (m_ie && (m_sf || m_pf)) || (m_pend && !clr_i);
      m_rd = (rd_addr == 1'b0) ? {2'b00, m_hold_en, m_ie, m_fac[3:0]}
                               : {5'b0, m_pend, m_pf, m_sf};
      m_pend = n_pend; m_hold = n_hold;
      m_sf = st || (m_sf && !clr_s);
      m_pf = sp || (m_pf && !clr_p);
      if (st) m_busy = 1; else if (sp) m_busy = 0;
      lvl_old = lvl;
      fac_now = m_fac;
      oldest = pin_q[0];
      for (int i = 0; i < 2; i++) begin
        if (oldest[i] == lvl[i]) run[i] = 0;
        else if (run[i] == fac_now) begin lvl[i] = oldest[i]; run[i] = 0; end
        else run[i]++;
      end
      if (wr_en && !wr_addr) begin
        m_fac = wr_data[3:0]; m_ie = wr_data[4]; m_hold_en = wr_data[5];
      end
      void'(pin_q.pop_front());
      pin_q.push_back({scl, sda});
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_addr) begin
        chk("R5 start flag vs model", rd_data[0], m_rd[0]);
        chk("R6 stop flag vs model", rd_data[1], m_rd[1]);
        chk("R9 pending vs model", rd_data[2], m_rd[2]);
      end else begin
        chk("R11 config readback vs model", rd_data, m_rd);
      end
      chk("R8 irq vs model", irq, m_pend);
      chk("R10 stop_hold vs model", stop_hold, m_hold);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic sda_pulse(input int len);
    @(negedge clk); sda = 0;
    tick(len); sda = 1;
    tick(30);
  endtask

  initial begin
    tick(4);
    chk("R1 rd_data in reset", rd_data, 0);
    chk("R1 irq in reset", irq, 0);
    chk("R1 stop_hold in reset", stop_hold, 0);
    rst = 0;
    tick(3);
    chk("R1 status after reset", rd_data, 0);
    rd_addr = 0; tick(2);
    chk("R1 config after reset", rd_data, 0);
    rd_addr = 1;

    // bypass: a one-cycle glitch passes
    sda_pulse(1);
    chk("R2 bypass glitch start+stop", rd_data[1:0], 3);
    wr(1, 8'h00); tick(3);
    chk("R7 write 0 keeps flags", rd_data[1:0], 3);
    wr(1, 8'h01); tick(3);
    chk("R7 clear start only", rd_data[1:0], 2);
    wr(1, 8'h02); tick(3);
    chk("R7 clear stop", rd_data[1:0], 0);

    // filter width 3
    wr(0, 8'h03);
    rd_addr = 0; tick(2);
    chk("R11 config readback", rd_data, 8'h03);
    rd_addr = 1;
    sda_pulse(3);
    chk("R3 pulse of n cycles rejected", rd_data[1:0], 0);
    sda_pulse(4);
    chk("R4 pulse of n+1 cycles passes", rd_data[1:0], 3);
    wr(1, 8'h03); tick(3);
    @(negedge clk); scl = 0; tick(1); scl = 1; tick(30);
    chk("R3 short scl dip rejected", rd_data[1:0], 0);

    // data toggles while clock low
    wr(0, 8'h00);
    @(negedge clk); scl = 0; tick(4); sda = 0; tick(4); sda = 1; tick(4);
    sda = 0; tick(4); scl = 1; tick(20);
    chk("R6 data change with clock low ignored", rd_data[1:0], 0);
    @(negedge clk); sda = 1; tick(20);
    chk("R6 stop detected", rd_data[1:0], 2);
    wr(1, 8'h02); tick(3);

    // start with irq and holdoff
    wr(0, 8'h30);
    stop_req = 1;
    @(negedge clk); sda = 0; tick(20);
    chk("R5 start detected", rd_data[1:0], 1);
    chk("R8 irq raised", irq, 1);
    chk("R10 holdoff while busy", stop_hold, 1);
    wr(1, 8'h04); tick(3);
    chk("R9 pending re-armed", irq, 1);
    wr(1, 8'h01); wr(1, 8'h04); tick(3);
    chk("R9 ordered clear", rd_data[2:0], 0);
    wr(0, 8'h10); tick(3);
    chk("R10 holdoff disabled", stop_hold, 0);
    wr(0, 8'h20); tick(3);
    chk("R10 holdoff re-enabled busy", stop_hold, 1);
    @(negedge clk); sda = 1; tick(20);
    chk("R6 stop flag", rd_data[1], 1);
    chk("R8 no irq when disabled", irq, 0);
    chk("R10 no holdoff when idle", stop_hold, 0);
    wr(0, 8'h30); tick(4);
    chk("R8 enable raises pending", irq, 1);
    wr(1, 8'h02); wr(1, 8'h04); tick(3);
    chk("R8 irq cleared", irq, 0);
    stop_req = 0;
    tick(5);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule